// File: doc/BRIEF.md
# Zero-Register Multi-Port Register File

This block is the general purpose register file of a small pipelined RISC-style core. It has two independent combinational read ports and one write port that commits on the rising clock edge. All three ports can be used in the same cycle. The decode stage presents two source specifiers and gets their operands back within the same cycle. The write-back stage presents a destination specifier, its data and an enable.

Index 0 is a constant zero. Both read ports return zero for it, and any write aimed at it is dropped. When a read specifier matches an enabled, non-zero write specifier in the same cycle, that read port returns the incoming write data instead of the stored value. The decode stage therefore sees a result that is being written back in that cycle, with no forwarding path outside the file.

Top module: `gpr_file`

## Requirements
- R1: The two read ports and the write port operate independently and all together in one cycle. Each read port returns the value a reference array model predicts for its own specifier.
- R2: The default configuration has 32 registers of 32 bits, and every register specifier is 5 bits wide.
- R3: A specifier of 0 on either read port returns all zeros in every cycle.
- R4: A write with specifier 0 is discarded. Index 0 still reads as zero in the same cycle and in every later cycle, whatever data was presented.
- R5: When write enable is 1, the write specifier is non-zero and a read specifier equals it, that read port returns the write data in the same cycle.
- R6: Reads are combinational from specifier to data. An enabled write to a non-zero index is committed at the rising clock edge and is returned from the next cycle onward.
- R7: With write enable 0, no register changes, and a read of the addressed index returns its old value in that cycle and in the next one.
- R8: While rst_ni is low, every register is cleared to zero, asynchronously to the clock.
- R9: When both read ports carry the same specifier, they return identical data, and this includes the case where the data is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all registers |
| we_i | input | 1 | Write enable |
| waddr_i | input | ADDR_W (5) | Write register specifier |
| wdata_i | input | DATA_W (32) | Write data |
| raddr_a_i | input | ADDR_W (5) | Read port A specifier |
| rdata_a_o | output | DATA_W (32) | Read port A data |
| raddr_b_i | input | ADDR_W (5) | Read port B specifier |
| rdata_b_o | output | DATA_W (32) | Read port B data |

## Verification
The hardest situation to produce from the ports is a same-cycle bypass on both read ports at once, on an index whose stored value differs from the incoming data. A bypass bug is invisible when the old and new values are the same. Directed steps first load a known pattern into a register. They then rewrite it with different data while both ports read it, and they repeat this at index 0 and at the top index. The random phase draws its write specifiers from a small index window and steers read specifiers onto the write specifier for about a third of the cycles, so that collisions occur often.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  parameter int unsigned RF_DEF_REGS  = 32;
  parameter int unsigned RF_DEF_WIDTH = 32;
  parameter int unsigned RF_NUM_RD    = 2;

  function automatic int unsigned rf_addr_w(input int unsigned regs);
    return (regs > 1) ? $clog2(regs) : 1;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
module rf_wr_decode #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  output logic [NUM_REGS-1:0] wen_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    if (i == 0) begin : g_zero
      assign wen_o[i] = 1'b0;  // index 0 never written
    end else begin : g_reg
      assign wen_o[i] = we_i && (waddr_i == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_REGS-1:0]          wen_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
  assign regs_o[DATA_W-1:0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= '0;
      else if (wen_i[i]) q <= wdata_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q;
  end

  logic unused_wen0;
  assign unused_wen0 = wen_i[0];
endmodule

// File: rtl/rf_rd_port.sv
`timescale 1ns/1ps
module rf_rd_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic              in_range;
  logic              is_zero;
  logic              hit;
  logic [DATA_W-1:0] stored;

  if (NUM_REGS == (1 << ADDR_W)) begin : g_full
    assign in_range = 1'b1;
  end else begin : g_partial
    assign in_range = (int'(raddr_i) < int'(NUM_REGS));
  end

  assign is_zero = (raddr_i == '0);
  // same-cycle write-to-read bypass, compare runs beside the mux
  assign hit     = we_i && (waddr_i != '0) && (waddr_i == raddr_i);

  always_comb begin
    stored = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr_i == ADDR_W'(i)) stored = regs_i[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (is_zero || !in_range) rdata_o = '0;
    else if (hit)             rdata_o = wdata_i;
    else                      rdata_o = stored;
  end
endmodule

// File: rtl/gpr_file.sv
`timescale 1ns/1ps
module gpr_file #(
  parameter int unsigned NUM_REGS = rf_pkg::RF_DEF_REGS,
  parameter int unsigned DATA_W   = rf_pkg::RF_DEF_WIDTH,
  localparam int unsigned ADDR_W  = rf_pkg::rf_addr_w(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned NUM_RD = rf_pkg::RF_NUM_RD;

  logic [NUM_REGS-1:0]        wen;
  logic [NUM_REGS*DATA_W-1:0] regs;
  logic [ADDR_W-1:0]          raddr [NUM_RD];
  logic [DATA_W-1:0]          rdata [NUM_RD];

  rf_wr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .we_i   (we_i),
    .waddr_i(waddr_i),
    .wen_o  (wen)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wen_i  (wen),
    .wdata_i(wdata_i),
    .regs_o (regs)
  );

  assign raddr[0] = raddr_a_i;
  assign raddr[1] = raddr_b_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
      .regs_i (regs),
      .raddr_i(raddr[p]),
      .we_i   (we_i),
      .waddr_i(waddr_i),
      .wdata_i(wdata_i),
      .rdata_o(rdata[p])
    );
  end

  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];
endmodule

// File: rtl/gpr_file_checker.sv
`timescale 1ns/1ps
module gpr_file_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ADDR_W-1:0] raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [ADDR_W-1:0] raddr_b_i,
  input logic [DATA_W-1:0] rdata_b_o
);
  logic past_valid;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  assert_zero_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));
  assert_zero_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));

  assert_bypass_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && raddr_a_i == waddr_i) |-> (rdata_a_o == wdata_i));
  assert_bypass_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && raddr_b_i == waddr_i) |-> (rdata_b_o == wdata_i));

  assert_commit_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid && $past(we_i) && $past(waddr_i) != '0 && raddr_a_i == $past(waddr_i)
     && !(we_i && waddr_i == raddr_a_i)) |-> (rdata_a_o == $past(wdata_i)));

  assert_hold_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid && !$past(we_i) && !we_i && $stable(raddr_a_i)) |-> $stable(rdata_a_o));

  assert_same_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == raddr_b_i) |-> (rdata_a_o == rdata_b_o));
endmodule

bind gpr_file gpr_file_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .waddr_i  (waddr_i),
  .wdata_i  (wdata_i),
  .raddr_a_i(raddr_a_i),
  .rdata_a_o(rdata_a_o),
  .raddr_b_i(raddr_b_i),
  .rdata_b_o(rdata_b_o)
);

// File: tb/gpr_file_bench.sv
`timescale 1ns/1ps
module gpr_file_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NR = 32;

  typedef struct {
    logic [DW-1:0] exp_a;
    logic [DW-1:0] exp_b;
    string         tag;
  } sb_item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] waddr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [AW-1:0] raddr_a_i = '0;
  logic [AW-1:0] raddr_b_i = '0;
  logic [DW-1:0] rdata_a_o;
  logic [DW-1:0] rdata_b_o;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [NR];
  sb_item_t sb[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpr_file u_gpr_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .waddr_i  (waddr_i),
    .wdata_i  (wdata_i),
    .raddr_a_i(raddr_a_i),
    .rdata_a_o(rdata_a_o),
    .raddr_b_i(raddr_b_i),
    .rdata_b_o(rdata_b_o)
  );

  function automatic logic [DW-1:0] predict(input logic we, input logic [AW-1:0] wa,
                                            input logic [DW-1:0] wd, input logic [AW-1:0] ra);
    if (ra == '0) return '0;
    if (we && wa != '0 && wa == ra) return wd;
    return model[ra];
  endfunction

  task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string tag);
    sb_item_t it;
    @(negedge clk_i);
    we_i = we; waddr_i = wa; wdata_i = wd; raddr_a_i = ra; raddr_b_i = rb;
    it.exp_a = predict(we, wa, wd, ra);
    it.exp_b = predict(we, wa, wd, rb);
    it.tag = tag;
    sb.push_back(it);
    if (we && wa != '0 && rst_ni) model[wa] = wd;
  endtask

  task automatic check_val(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      while (sb.size() > 0) begin
        sb_item_t it;
        it = sb.pop_front();
        check_val({it.tag, " port A"}, rdata_a_o, it.exp_a);
        check_val({it.tag, " port B"}, rdata_b_o, it.exp_b);
      end
    end
  end

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; we_i = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    for (int i = 0; i < NR; i += 2) step(1'b0, AW'(i), '0, AW'(i), AW'(i+1), "R8 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    // R2: specifier width
    checks++;
    if ($bits(raddr_a_i) != 5 || $bits(rdata_a_o) != 32) begin
      failures++;
      $display("FAIL R2 width got=%0d exp=5", $bits(raddr_a_i));
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // r8_ reset state
    for (int i = 0; i < NR; i += 2) step(1'b0, '0, '0, AW'(i), AW'(i+1), "R8 after reset");

    // R5 / R9: bypass on both ports with data differing from stored
    step(1'b1, 5'd5, 32'h1111_2222, 5'd0, 5'd0, "R5 preload");
    step(1'b1, 5'd5, 32'hA5A5_0F0F, 5'd5, 5'd5, "R5 R9 bypass both");
    step(1'b0, 5'd0, '0, 5'd5, 5'd3, "R6 next cycle");

    // R3 / R4: write to zero
    step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd5, "R4 same cycle");
    step(1'b0, 5'd0, '0, 5'd1, 5'd0, "R3 R4 next cycle");

    // R7: disabled write leaves data
    step(1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd5, "R7 we low same");
    step(1'b0, 5'd0, '0, 5'd5, 5'd0, "R7 we low next");

    // top index
    step(1'b1, 5'd31, 32'h7777_8888, 5'd31, 5'd30, "R5 top index");
    step(1'b1, 5'd31, 32'h0123_4567, 5'd30, 5'd31, "R5 top rewrite");
    step(1'b0, 5'd0, '0, 5'd31, 5'd31, "R6 top readback");

    // R1 random with steered collisions
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [AW-1:0] wa, ra, rb;
      logic [DW-1:0] wd;
      we = ($urandom_range(0, 3) != 0);
      wa = (n < 2000) ? AW'($urandom_range(0, 3)) : AW'($urandom);
      wd = $urandom;
      ra = ($urandom_range(0, 2) == 0) ? wa : AW'($urandom);
      rb = ($urandom_range(0, 2) == 0) ? wa : ($urandom_range(0, 3) == 0 ? ra : AW'($urandom));
      step(we, wa, wd, ra, rb, "R1 random");
    end

    // R8: async reset after the file is full
    for (int i = 1; i < NR; i++) step(1'b1, AW'(i), DW'(32'hC000_0000 + i), '0, '0, "R8 fill");
    do_reset();
    for (int i = 0; i < NR; i += 2) step(1'b0, '0, '0, AW'(i), AW'(i+1), "R8 after midrun reset");

    repeat (3) @(negedge clk_i);
    summary_and_end();
  end
endmodule